// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Write Controller

This block guards and times single-byte updates to a small on-chip nonvolatile data array. Software loads an address register and a data register. It then writes the control register twice. The first write raises a short-lived arming bit. The second write raises the write strobe while the arming bit is still high. Only that pairing starts a programming operation. A stray strobe, a late strobe, a strobe in the reserved mode, or a strobe while the flash self-programming engine is busy has no effect.

Once a write is accepted, the strobe bit reads as one for the whole programming time and then drops, so software can poll it. The CPU is held for two cycles. The array is modelled as a register file whose erased value is all ones. The programming time depends on the mode: the full erase-plus-write takes the long time, and erase-only and write-only take the short time. Both times are cycle-count parameters.

A level-style ready interrupt is asserted whenever the interrupt enable, the global interrupt flag and an idle strobe all hold, and flash self-programming is not active. Each finished operation is reported on a one-cycle result output. This output has no ready input and cannot be back-pressured: a consumer that needs the result must take it in the cycle it is shown.

Top module: `nvm_write_guard`

## Requirements
- R1: A control write with bit 1 (arm) set and no accepted strobe makes `arm_o` read 1 for exactly four cycles. After that it returns to 0, unless it is armed again. An accepted strobe clears it at once.
- R2: A control write with bit 2 (strobe) set while `arm_o` is 0 has no effect. `strobe_o` stays 0, `cpu_stall` stays 0 and no operation is reported.
- R3: A strobe write is accepted when `arm_o` is 1, no write is in progress and the mode field (control bits 4:3, taken from the same write) is not 11. `strobe_o` then reads 1 for exactly T_FULL cycles in mode 00, or T_HALF cycles in modes 01 and 10, and then reads 0.
- R4: While `flash_busy` is 1, a strobe write does not start a write.
- R5: A strobe write made while `strobe_o` is 1 is ignored. It does not restart or extend the write in progress.
- R6: On acceptance, `cpu_stall` is 1 for exactly the two cycles that follow the accepting edge.
- R7: `irq_ready` equals enable (control bit 0) AND `gie` AND NOT `strobe_o` AND NOT `flash_busy`.
- R8: The address (select 1) and data (select 2) are captured when a write is accepted. Register writes made while the write is busy do not change its target or its value.
- R9: When the write finishes, the addressed byte becomes the data in mode 00, 0xFF in mode 01, and the old byte AND the data in mode 10. `op_valid` is 1 for one cycle, in the cycle in which `strobe_o` first reads 0, with the address in `op_addr` and the new byte in `op_byte`.
- R10: A strobe write with mode 11 starts nothing. `strobe_o` stays 0 and no stall follows.
- R11: A synchronous reset clears enable, arm, strobe, stall and any write in progress, and sets every array byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 none |
| reg_wdata | input | 8 | Register write data |
| gie | input | 1 | Global interrupt flag |
| flash_busy | input | 1 | Flash self-programming active |
| irq_ready | output | 1 | Level ready interrupt |
| cpu_stall | output | 1 | CPU hold request |
| arm_o | output | 1 | Arming bit read-back |
| strobe_o | output | 1 | Write strobe / busy read-back |
| op_valid | output | 1 | One-cycle completion pulse |
| op_addr | output | ADDR_W | Address of the finished operation |
| op_byte | output | 8 | Byte stored by the finished operation |

## Verification
A wrong arming count shows up on `arm_o` in the cycle it diverges. It also shows a few cycles later as a strobe that is accepted or refused against the window. A wrong programming counter shows as `strobe_o` falling early or late, to the exact cycle. A corrupted captured address or data only shows at completion, on `op_addr` and `op_byte`. Because of that, the bench changes both registers during busy periods and compares every cycle against its own model of the array contents.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_RSVD  = 2'b11
  } nvw_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } nvw_sel_e;

  localparam int ARM_WINDOW = 4;
  localparam int B_IE       = 0;
  localparam int B_ARM      = 1;
  localparam int B_STB      = 2;
  localparam int B_MODE     = 3;

  function automatic logic [7:0] nvw_merge(nvw_mode_e m, logic [7:0] old_b, logic [7:0] d);
    case (m)
      MODE_FULL:  return d;
      MODE_ERASE: return 8'hFF;
      MODE_WRITE: return old_b & d;
      default:    return old_b;
    endcase
  endfunction
endpackage

// File: rtl/nvw_arm_window.sv
module nvw_arm_window
  import nvw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic arm_o
);
  localparam int CW = $clog2(ARM_WINDOW + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_o <= 1'b0;
      cnt   <= '0;
    end else if (clr_i) begin
      arm_o <= 1'b0;
      cnt   <= '0;
    end else if (set_i) begin
      arm_o <= 1'b1;
      cnt   <= CW'(ARM_WINDOW);
    end else if (arm_o) begin
      if (cnt == CW'(1)) arm_o <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

  p_arm_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> arm_o);
  p_arm_expire_r1: assert property (@(posedge clk) disable iff (rst)
    (arm_o && cnt == CW'(1) && !set_i) |=> !arm_o);
endmodule

// File: rtl/nvw_prog_timer.sv
module nvw_prog_timer
  import nvw_pkg::*;
#(
  parameter int T_FULL = 68,
  parameter int T_HALF = 36
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  nvw_mode_e mode_i,
  output logic      busy_o,
  output logic      done_o,
  output logic      stall_o
);
  localparam int TW = $clog2(T_FULL + 1);
  logic [TW-1:0] tleft;
  logic [1:0]    scnt;

  assign done_o  = busy_o && (tleft == TW'(1));
  assign stall_o = (scnt != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      tleft  <= '0;
      scnt   <= 2'd0;
    end else begin
      if (scnt != 2'd0) scnt <= scnt - 2'd1;
      if (start_i) begin
        busy_o <= 1'b1;
        tleft  <= (mode_i == MODE_FULL) ? TW'(T_FULL) : TW'(T_HALF);
        scnt   <= 2'd2;
      end else if (busy_o) begin
        if (done_o) busy_o <= 1'b0;
        tleft <= tleft - TW'(1);
      end
    end
  end

  p_stall_two_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> stall_o ##1 stall_o ##1 !stall_o);
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !start_i);
endmodule

// File: rtl/nvw_cell_array.sv
module nvw_cell_array
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  nvw_mode_e         mode_i,
  input  logic              done_i,
  output logic              op_valid,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_byte
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] c_addr;
  logic [7:0]        c_data;
  nvw_mode_e         c_mode;
  logic [7:0]        nxt;

  assign nxt = nvw_merge(c_mode, mem[c_addr], c_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      c_addr   <= '0;
      c_data   <= '0;
      c_mode   <= MODE_FULL;
      op_valid <= 1'b0;
      op_addr  <= '0;
      op_byte  <= 8'hFF;
    end else begin
      op_valid <= 1'b0;
      if (start_i) begin
        c_addr <= addr_i;
        c_data <= data_i;
        c_mode <= mode_i;
      end
      if (done_i) begin
        mem[c_addr] <= nxt;
        op_valid    <= 1'b1;
        op_addr     <= c_addr;
        op_byte     <= nxt;
      end
    end
  end

  p_op_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);
  p_erase_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (done_i && c_mode == MODE_ERASE) |=> (op_byte == 8'hFF));
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int T_FULL = 68,
  parameter int T_HALF = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              gie,
  input  logic              flash_busy,
  output logic              irq_ready,
  output logic              cpu_stall,
  output logic              arm_o,
  output logic              strobe_o,
  output logic              op_valid,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_byte
);
  logic              ie_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              ctrl_wr, accept, arm_set, done;
  nvw_mode_e         wmode;

  assign ctrl_wr = reg_we && (nvw_sel_e'(reg_sel) == SEL_CTRL);
  assign wmode   = nvw_mode_e'(reg_wdata[B_MODE +: 2]);
  assign accept  = ctrl_wr && reg_wdata[B_STB] && arm_o && !strobe_o
                   && !flash_busy && (wmode != MODE_RSVD);
  assign arm_set = ctrl_wr && reg_wdata[B_ARM] && !accept;
  assign irq_ready = ie_q && gie && !strobe_o && !flash_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (reg_we) begin
      case (nvw_sel_e'(reg_sel))
        SEL_CTRL: ie_q   <= reg_wdata[B_IE];
        SEL_ADDR: addr_q <= reg_wdata[ADDR_W-1:0];
        SEL_DATA: data_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  nvw_arm_window u_arm (
    .clk(clk), .rst(rst), .set_i(arm_set), .clr_i(accept), .arm_o(arm_o)
  );

  nvw_prog_timer #(.T_FULL(T_FULL), .T_HALF(T_HALF)) u_tmr (
    .clk(clk), .rst(rst), .start_i(accept), .mode_i(wmode),
    .busy_o(strobe_o), .done_o(done), .stall_o(cpu_stall)
  );

  nvw_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst(rst), .start_i(accept), .addr_i(addr_q), .data_i(data_q),
    .mode_i(wmode), .done_i(done), .op_valid(op_valid), .op_addr(op_addr),
    .op_byte(op_byte)
  );

  p_flash_block_r4: assert property (@(posedge clk) disable iff (rst)
    (flash_busy && !strobe_o) |=> !strobe_o);
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe_o || flash_busy) |-> !irq_ready);
  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wmode == MODE_RSVD && !strobe_o) |=> !strobe_o);
  p_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
    (!arm_o && !strobe_o) |=> !strobe_o);
endmodule

// File: tb/sim_nvm_write_guard.sv
`timescale 1ns/100ps
module sim_nvm_write_guard;
  localparam int AW = 4;
  localparam int TF = 20;
  localparam int TH = 11;

  logic clk = 0, rst = 1, reg_we = 0, gie = 0, flash_busy = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic irq_ready, cpu_stall, arm_o, strobe_o, op_valid;
  logic [AW-1:0] op_addr;
  logic [7:0] op_byte;

  int vectors = 0, errors = 0;
  string req = "R11";

  nvm_write_guard #(.ADDR_W(AW), .T_FULL(TF), .T_HALF(TH)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .gie(gie), .flash_busy(flash_busy), .irq_ready(irq_ready), .cpu_stall(cpu_stall),
    .arm_o(arm_o), .strobe_o(strobe_o), .op_valid(op_valid), .op_addr(op_addr),
    .op_byte(op_byte));

  always #2.5 clk = ~clk;

  // behavioural reference model
  int m_ie, m_arm, m_armcnt, m_stb, m_tleft, m_stall, m_addr, m_data;
  int m_caddr, m_cdata, m_cmode, m_opv, m_opaddr, m_opbyte;
  int arr[16];

  always @(posedge clk) begin
    if (rst) begin
      m_ie = 0; m_arm = 0; m_armcnt = 0; m_stb = 0; m_tleft = 0; m_stall = 0;
      m_addr = 0; m_data = 0; m_caddr = 0; m_cdata = 0; m_cmode = 0;
      m_opv = 0; m_opaddr = 0; m_opbyte = 255;
      foreach (arr[i]) arr[i] = 255;
    end else begin
      int o_arm, o_stb, md;
      o_arm = m_arm; o_stb = m_stb;
      m_opv = 0;
      if (m_stb) begin
        m_tleft--;
        if (m_tleft == 0) begin
          if (m_cmode == 0) arr[m_caddr] = m_cdata;
          else if (m_cmode == 1) arr[m_caddr] = 255;
          else arr[m_caddr] = arr[m_caddr] & m_cdata;
          m_stb = 0; m_opv = 1; m_opaddr = m_caddr; m_opbyte = arr[m_caddr];
        end
      end
      if (m_stall > 0) m_stall--;
      if (m_arm) begin m_armcnt--; if (m_armcnt == 0) m_arm = 0; end
      if (reg_we) begin
        if (reg_sel == 1) m_addr = reg_wdata % 16;
        else if (reg_sel == 2) m_data = reg_wdata;
        else if (reg_sel == 0) begin
          m_ie = reg_wdata[0];
          md = reg_wdata[4:3];
          if (reg_wdata[2] && o_arm && !o_stb && !flash_busy && md != 3) begin
            m_stb = 1; m_tleft = (md == 0) ? TF : TH; m_stall = 2; m_arm = 0;
            m_caddr = m_addr; m_cdata = m_data; m_cmode = md;
          end else if (reg_wdata[1]) begin
            m_arm = 1; m_armcnt = 4;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s actual=%0h expected=%0h t=%0t", req, tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 arm", arm_o, m_arm);
      chk("R3 strobe", strobe_o, m_stb);
      chk("R6 stall", cpu_stall, m_stall > 0);
      chk("R7 irq", irq_ready, m_ie && gie && !m_stb && !flash_busy);
      chk("R9 valid", op_valid, m_opv);
      if (m_opv) begin
        chk("R9 addr", op_addr, m_opaddr);
        chk("R9 byte", op_byte, m_opbyte);
      end
    end
  end

  task automatic wr(int sel, int d);
    @(negedge clk); #1;
    reg_we = 1; reg_sel = 2'(sel); reg_wdata = 8'(d);
    @(negedge clk); #1;
    reg_we = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  // control byte: bit0 enable, bit1 arm, bit2 strobe, bits4:3 mode
  task automatic arm_go(int mode, int gap);
    wr(0, 8'h03);
    idle(gap);
    wr(0, 8'h05 | (mode << 3));
  endtask
  task automatic wait_idle();
    int k = 0;
    while (strobe_o && k < 100) begin @(negedge clk); k++; end
    idle(2);
  endtask

  initial begin
    int guard = 0;
    fork
      begin
        idle(3); #1; rst = 0;
        req = "R11"; idle(1);
        chk("R11 reset arm", arm_o, 0); chk("R11 reset strobe", strobe_o, 0);
        req = "R2"; wr(0, 8'h05); idle(3);
        req = "R3"; wr(1, 3); wr(2, 8'h5A); arm_go(0, 0);
        req = "R8"; wr(1, 7); wr(2, 8'h11); wait_idle();
        req = "R9"; wr(1, 3); arm_go(1, 1); wait_idle();
        wr(2, 8'hF0); arm_go(2, 0); wait_idle();
        wr(2, 8'h3C); arm_go(2, 2); wait_idle();
        req = "R1"; wr(2, 8'h00); arm_go(0, 4); wait_idle();
        arm_go(0, 5); wait_idle();
        arm_go(0, 7); idle(3);
        req = "R4"; flash_busy = 1; arm_go(0, 0); idle(3); flash_busy = 0; idle(2);
        req = "R10"; arm_go(3, 0); idle(4);
        req = "R5"; wr(1, 9); wr(2, 8'hA5); arm_go(1, 0); idle(2);
        arm_go(0, 0); wait_idle();
        req = "R7"; wr(0, 8'h01); gie = 1; idle(2); flash_busy = 1; idle(2);
        flash_busy = 0; gie = 0; idle(2); gie = 1; wr(2, 8'h42); arm_go(0, 0); wait_idle();
        req = "R11"; wr(0, 8'h03); wr(0, 8'h05); idle(3);
        @(negedge clk); #1; rst = 1; @(negedge clk); #1; rst = 0; idle(1);
        chk("R11 strobe cleared", strobe_o, 0); chk("R11 stall cleared", cpu_stall, 0);
        chk("R11 irq cleared", irq_ready, 0);
        wr(1, 3); wr(2, 8'h0F); arm_go(2, 0); wait_idle();
      end
      begin
        while (guard < 20000) begin @(posedge clk); guard++; end
        errors++; vectors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule